// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is the arithmetic slice of a processor execute stage. It forms the sum or difference of two operands, with five operations selected by a 3-bit code: plain add, add with incoming carry, subtract, subtract with incoming carry, and reverse subtract (second operand minus first). The result leaves the block combinationally in the same cycle as its inputs. Four condition flags sit in a small register: negative, zero, carry and signed overflow.

Every operation is reduced to one addition of a steered pair plus a carry-in. The first operand is added to the second one for adds. It is added to the inverted second one for subtracts. For reverse subtract the roles of the two operands are swapped. On a subtract the carry flag therefore reads "no borrow". The flag register loads the flags of the current operation at a rising clock edge only while the set-flags input is high. Otherwise it holds its contents. A synchronous reset clears all four flags.

Top module: `arith_nzcv_unit`

## Requirements
- R1: After a clock edge with set_flags high and rst low, flag_n equals bit 31 of the result presented in that cycle.
- R2: After such an update, flag_z is 1 exactly when all 32 bits of that result were zero.
- R3: op_sel 3'b000 gives result = a + b, and op_sel 3'b001 gives a + b + carry_in, both modulo 2^32. After an update, flag_c is the unsigned carry out of bit 31.
- R4: op_sel 3'b010 gives result = a - b, and op_sel 3'b011 gives a - b - 1 + carry_in. After an update, flag_c is 0 when the subtraction borrows and 1 when it does not (for 3'b010: flag_c = 1 exactly when a >= b unsigned).
- R5: op_sel 3'b100 gives result = b - a. After an update, flag_c = 1 exactly when b >= a unsigned.
- R6: After an update, flag_v is 1 exactly when the operation, read as two's-complement signed arithmetic, overflowed the 32-bit result.
- R7: While set_flags is low, the four flags keep their values across clock edges whatever the other inputs do.
- R8: rst high at a clock edge clears all four flags, even when set_flags is high in that cycle.
- R9: carry_in has no effect on op_sel 3'b000, 3'b010 or 3'b100. The unused codes 3'b101, 3'b110 and 3'b111 behave exactly as 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_sel | input | 3 | Operation code (see R3, R4, R5, R9) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| carry_in | input | 1 | Incoming carry for the with-carry forms |
| set_flags | input | 1 | Load the flag register at the next edge |
| result | output | 32 | Combinational sum or difference |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry / no-borrow flag |
| flag_v | output | 1 | Registered signed-overflow flag |

## Verification
Properties check on every flag update that the negative and zero flags match the result driven in the cycle before. They also check the carry flag against an independent unsigned compare or a wide sum for the plain add, subtract and reverse-subtract codes, and the overflow flag of the plain add against a sign-extended sum. A separate property checks that the flags hold while updates are disabled. Some behaviours can only be shown by the bench's scenarios: the exact result values of all five operations, the with-carry forms, the unused codes, carry_in being ignored, and reset winning over a simultaneous update. The bench covers these with a table of hand-worked vectors and directed sequences.

// File: rtl/arith_nzcv_pkg.sv
package arith_nzcv_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_RSB = 3'd4
    } arith_op_e;

    // Registered condition flags
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // How the operand pair and carry-in are formed for one addition
    typedef struct packed {
        logic swap;      // add b then a instead of a then b
        logic invert;    // invert the second addend
        logic cin_ext;   // take carry-in from the carry_in input
        logic cin_one;   // constant carry-in value when cin_ext is low
    } steer_t;

    function automatic steer_t decode_op(input logic [OP_W-1:0] code);
        steer_t s;
        s = '0;
        case (code)
            OP_ADC: s.cin_ext = 1'b1;
            OP_SUB: begin s.invert = 1'b1; s.cin_one = 1'b1; end
            OP_SBC: begin s.invert = 1'b1; s.cin_ext = 1'b1; end
            OP_RSB: begin s.swap = 1'b1; s.invert = 1'b1; s.cin_one = 1'b1; end
            default: s = '0;   // plain add, also for unused codes
        endcase
        return s;
    endfunction

    // Signed overflow from the sign bits of both addends and the sum
    function automatic logic signed_ovf(input logic x_msb, input logic y_msb,
                                        input logic r_msb);
        return (x_msb == y_msb) && (r_msb != x_msb);
    endfunction

endpackage

// File: rtl/arith_opsel.sv
module arith_opsel
    import arith_nzcv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              cy_flag,
    output logic [DATA_W-1:0] add_x,
    output logic [DATA_W-1:0] add_y,
    output logic              add_cin
);

    steer_t ctl;

    always_comb begin
        ctl     = decode_op(op_code);
        add_x   = ctl.swap ? in_b : in_a;
        add_y   = ctl.swap ? in_a : in_b;
        if (ctl.invert) begin
            add_y = ~add_y;
        end
        add_cin = ctl.cin_ext ? cy_flag : ctl.cin_one;
    end

endmodule

// File: rtl/arith_adder.sv
module arith_adder #(
    parameter int DATA_W     = 32,
    parameter int ADDER_KIND = 0     // 0: inferred adder, 1: explicit ripple chain
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);

    localparam int EXT_W = DATA_W + 1;

    generate
        if (ADDER_KIND == 1) begin : g_ripple
            logic [DATA_W:0] cy;
            assign cy[0] = cin;
            for (genvar i = 0; i < DATA_W; i++) begin : g_bit
                assign sum[i]  = x[i] ^ y[i] ^ cy[i];
                assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
            end
            assign cout = cy[DATA_W];
        end else begin : g_infer
            logic [EXT_W-1:0] wide;
            assign wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
            assign sum  = wide[DATA_W-1:0];
            assign cout = wide[DATA_W];
        end
    endgenerate

endmodule

// File: rtl/arith_flag_reg.sv
module arith_flag_reg
    import arith_nzcv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] sum,
    input  logic              cout,
    input  logic              x_msb,
    input  logic              y_msb,
    output nzcv_t             flags
);

    nzcv_t nxt;

    always_comb begin
        nxt.n = sum[DATA_W-1];
        nxt.z = (sum == '0);
        nxt.c = cout;
        nxt.v = signed_ovf(x_msb, y_msb, sum[DATA_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (load) begin
            flags <= nxt;
        end
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(flags));   // R7

endmodule

// File: rtl/arith_nzcv_unit.sv
module arith_nzcv_unit
    import arith_nzcv_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDER_KIND = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    input  logic              set_flags,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] add_x;
    logic [DATA_W-1:0] add_y;
    logic              add_cin;
    logic [DATA_W-1:0] sum;
    logic              cout;
    nzcv_t             flags_q;

    arith_opsel #(.DATA_W(DATA_W)) i_opsel (
        .op_code (op_sel),
        .in_a    (opnd_a),
        .in_b    (opnd_b),
        .cy_flag (carry_in),
        .add_x   (add_x),
        .add_y   (add_y),
        .add_cin (add_cin)
    );

    arith_adder #(.DATA_W(DATA_W), .ADDER_KIND(ADDER_KIND)) i_adder (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (sum),
        .cout (cout)
    );

    arith_flag_reg #(.DATA_W(DATA_W)) i_flags (
        .clk   (clk),
        .rst   (rst),
        .load  (set_flags),
        .sum   (sum),
        .cout  (cout),
        .x_msb (add_x[MSB]),
        .y_msb (add_y[MSB]),
        .flags (flags_q)
    );

    assign result = sum;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    // Independent reference terms for the checks below
    logic [DATA_W:0] ref_usum;
    logic [DATA_W:0] ref_ssum;
    assign ref_usum = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign ref_ssum = {opnd_a[MSB], opnd_a} + {opnd_b[MSB], opnd_b};

    AST_NEG_BIT: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> flag_n == $past(result[MSB]));   // R1

    AST_ZERO_DETECT: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> flag_z == ($past(result) == '0));   // R2

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_sel == OP_ADD) |=> flag_c == $past(ref_usum[DATA_W]));   // R3

    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_sel == OP_SUB) |=> flag_c == $past(opnd_a >= opnd_b));   // R4

    AST_RSB_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_sel == OP_RSB) |=> flag_c == $past(opnd_b >= opnd_a));   // R5

    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_sel == OP_ADD) |=>
            flag_v == $past(ref_ssum[DATA_W] != ref_ssum[MSB]));   // R6

endmodule

// File: tb/test_arith_nzcv_unit.sv
`timescale 1ns/100ps
module test_arith_nzcv_unit;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        cin;
        logic [31:0] res;
        logic [3:0]  nzcv;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h0000_0001, 32'h0000_0002, 1'b1, 32'h0000_0003, 4'b0000},
        '{3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 4'b0110},
        '{3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 4'b1001},
        '{3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 4'b0111},
        '{3'd1, 32'h0000_0005, 32'h0000_0006, 1'b1, 32'h0000_000C, 4'b0000},
        '{3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 4'b0110},
        '{3'd2, 32'h0000_0005, 32'h0000_0003, 1'b0, 32'h0000_0002, 4'b0010},
        '{3'd2, 32'h0000_0003, 32'h0000_0005, 1'b1, 32'hFFFF_FFFE, 4'b1000},
        '{3'd2, 32'h0000_0005, 32'h0000_0005, 1'b0, 32'h0000_0000, 4'b0110},
        '{3'd2, 32'h8000_0000, 32'h0000_0001, 1'b0, 32'h7FFF_FFFF, 4'b0011},
        '{3'd3, 32'h0000_0005, 32'h0000_0003, 1'b0, 32'h0000_0001, 4'b0010},
        '{3'd3, 32'h0000_0005, 32'h0000_0003, 1'b1, 32'h0000_0002, 4'b0010},
        '{3'd3, 32'h0000_0000, 32'h0000_0000, 1'b0, 32'hFFFF_FFFF, 4'b1000},
        '{3'd4, 32'h0000_0003, 32'h0000_000A, 1'b0, 32'h0000_0007, 4'b0010},
        '{3'd4, 32'h0000_000A, 32'h0000_0003, 1'b1, 32'hFFFF_FFF9, 4'b1000},
        '{3'd4, 32'h0000_0001, 32'h8000_0000, 1'b0, 32'h7FFF_FFFF, 4'b0011},
        '{3'd6, 32'h0000_0001, 32'h0000_0002, 1'b1, 32'h0000_0003, 4'b0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    arith_nzcv_unit i_arith_nzcv_unit (
        .clk       (clk),
        .rst       (rst),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .set_flags (set_flags),
        .result    (result),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .flag_v    (flag_v)
    );

    function automatic string req_of(input logic [2:0] op, input logic cin);
        case (op)
            3'd0:    return cin ? "R3 R9" : "R3";
            3'd1:    return "R3";
            3'd2:    return cin ? "R4 R9" : "R4";
            3'd3:    return "R4";
            3'd4:    return cin ? "R5 R9" : "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] flags_now();
        return {28'd0, flag_n, flag_z, flag_c, flag_v};
    endfunction

    task automatic apply(input vec_t v, input logic upd);
        op_sel    = v.op;
        opnd_a    = v.a;
        opnd_b    = v.b;
        carry_in  = v.cin;
        set_flags = upd;
    endtask

    initial begin
        #(5.0 * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: flags clear out of reset
        chk("R8 reset state", flags_now(), 32'h0);

        // Vector table: result checked before the edge, flags after it
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k], 1'b1);
            #1;
            chk(req_of(VECS[k].op, VECS[k].cin), result, VECS[k].res);
            @(negedge clk);
            chk({req_of(VECS[k].op, VECS[k].cin), " R1/R2/R6 flags"},
                flags_now(), {28'd0, VECS[k].nzcv});
        end

        // R7: load Z and C, then present a different operation with set_flags low
        apply(VECS[1], 1'b1);
        @(negedge clk);
        chk("R7 preload", flags_now(), 32'h6);
        apply(VECS[2], 1'b0);
        #1;
        chk("R7 result live", result, 32'h8000_0000);
        repeat (2) @(negedge clk);
        chk("R7 hold", flags_now(), 32'h6);

        // R8: reset wins over a simultaneous update
        apply(VECS[3], 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 reset over update", flags_now(), 32'h0);
        rst = 1'b0;
        apply(VECS[3], 1'b1);
        @(negedge clk);
        chk("R8 update after reset", flags_now(), 32'h7);

        // R9: code 3'b111 acts as add, carry_in ignored
        apply('{3'd7, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 32'h0, 4'b0}, 1'b1);
        #1;
        chk("R9 code 7 result", result, 32'h0);
        @(negedge clk);
        chk("R9 code 7 flags", flags_now(), 32'h6);
        set_flags = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule